// File: doc/BRIEF.md
# Slotted Microprogram Frame Sequencer

This block is the timing core of a time-division voice-synthesis engine. It divides a repeating frame into 64 process slots of 16 clock steps each. At the first step of every slot it looks up, in a per-slot table, which of 32 stored algorithms the slot runs. It then issues that algorithm's 16 micro-instruction words, one per clock, from a shared program memory. Alongside each word it presents the slot and step numbers, a copy of the slot index for each of five parameter bank address buses, a per-slot chaining flag and start-of-slot and start-of-frame strobes. The datapath uses these outputs to fetch per-voice parameters and to decide whether to clear its accumulator.

A host loads the per-slot table (algorithm index plus chaining bit) and the program memory through two write ports. A change never disturbs a slot already in progress. The table entry and the whole 16-word program of the running algorithm are captured at the slot's first step, so a write becomes visible at the next slot boundary. All outputs are registered and mutually aligned: the word on the instruction output belongs to the slot and step shown next to it.

Top module: `frame_sequencer`

## Requirements
- R1: The displayed step advances by one every clock and wraps from 15 to 0. The displayed slot advances by one when the step wraps and goes from 63 back to 0.
- R2: The instruction output equals program word at address {algorithm[4:0], step[3:0]}, where algorithm is the table entry of the displayed slot and step is the displayed step. The word appears in the same cycle as its slot and step values.
- R3: A table write made while a slot is running does not change that slot's remaining words. A write to the entry of a slot not yet reached takes effect on that slot's next visit.
- R4: A program memory write made while a slot is running does not change that slot's remaining words. Any later slot that runs the same algorithm issues the new word.
- R5: The chaining output equals the table's link bit for the displayed slot and stays constant across all 16 steps of that slot.
- R6: The frame strobe is 1 only when slot 0 step 0 is displayed. The slot strobe is 1 exactly when step 0 is displayed.
- R7: Each of the five bank address fields (bank b at bits [6b+5:6b]) equals the displayed slot in the same cycle.
- R8: While reset is low, every output is 0 and table writes are ignored. After reset the sequence starts at slot 0 step 0, and every slot runs algorithm 0 with link bit 0 until it is rewritten. Program writes are accepted while reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tbl_we | input | 1 | Per-slot table write enable |
| tbl_slot | input | 6 | Slot entry to write |
| tbl_alg | input | 5 | Algorithm index to store |
| tbl_link | input | 1 | Chaining bit to store |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | 9 | Program address {algorithm, step} |
| prog_data | input | 32 | Program word |
| uinstr_o | output | 32 | Registered micro-instruction word |
| slot_o | output | 6 | Slot of the word shown |
| step_o | output | 4 | Step of the word shown |
| frame_start_o | output | 1 | One-cycle pulse at slot 0 step 0 |
| slot_start_o | output | 1 | One-cycle pulse at step 0 of every slot |
| link_continue_o | output | 1 | Slot continues the previous slot's process |
| bank_base_o | output | 30 | Five copies of the slot index, one per parameter bank |

## Verification
A wrong slot or step count shows at once in the position outputs and the strobes, and the slot error then repeats every frame. A wrong table or latch state shows as a wrong word at the next step-0 boundary and persists for all 16 steps of that slot. A failure to isolate writes shows only in the remainder of the slot being written, so the bench writes mid-slot and compares every following word against a snapshot taken at step 0. An exhaustive sweep over three full frames with distinct words for every {algorithm, step} pair covers each table entry and each program word.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int DEF_SLOTS  = 64;
  localparam int DEF_STEPS  = 16;
  localparam int DEF_ALGS   = 32;
  localparam int DEF_UW     = 32;
  localparam int DEF_NBANKS = 5;
endpackage

// File: rtl/fseq_rst_sync.sv
module fseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/fseq_counter.sv
module fseq_counter #(
  parameter int SLOTS = fseq_pkg::DEF_SLOTS,
  parameter int STEPS = fseq_pkg::DEF_STEPS,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int STEP_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot_c,
  output logic [STEP_W-1:0] step_c,
  output logic              first_step,
  output logic              frame_head
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_wrap;

  always_comb begin
    step_wrap = (step_q == STEP_LAST);
    step_d    = step_wrap ? '0 : step_q + 1'b1;
    slot_d    = slot_q;
    if (step_wrap) begin
      slot_d = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      step_q <= '0;
    end else begin
      slot_q <= slot_d;
      step_q <= step_d;
    end
  end

  assign slot_c     = slot_q;
  assign step_c     = step_q;
  assign first_step = (step_q == '0);
  assign frame_head = (step_q == '0) && (slot_q == '0);
endmodule

// File: rtl/fseq_slot_table.sv
module fseq_slot_table #(
  parameter int SLOTS = fseq_pkg::DEF_SLOTS,
  parameter int ALGS  = fseq_pkg::DEF_ALGS,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ALG_W  = $clog2(ALGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [ALG_W-1:0]  walg,
  input  logic              wlink,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [ALG_W-1:0]  rd_alg,
  output logic              rd_link
);
  logic [SLOTS*ALG_W-1:0] alg_flat;
  logic [SLOTS-1:0]       link_flat;

  for (genvar i = 0; i < SLOTS; i++) begin : g_entry
    logic             hit;
    logic [ALG_W-1:0] alg_q, alg_d;
    logic             link_q, link_d;

    always_comb begin
      hit    = we && (wslot == SLOT_W'(i));
      alg_d  = hit ? walg  : alg_q;
      link_d = hit ? wlink : link_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alg_q  <= '0;
        link_q <= 1'b0;
      end else begin
        alg_q  <= alg_d;
        link_q <= link_d;
      end
    end

    assign alg_flat[i*ALG_W +: ALG_W] = alg_q;
    assign link_flat[i]               = link_q;
  end

  assign rd_alg  = alg_flat[rd_slot*ALG_W +: ALG_W];
  assign rd_link = link_flat[rd_slot];
endmodule

// File: rtl/fseq_prog_store.sv
module fseq_prog_store #(
  parameter int ALGS  = fseq_pkg::DEF_ALGS,
  parameter int STEPS = fseq_pkg::DEF_STEPS,
  parameter int UW    = fseq_pkg::DEF_UW,
  localparam int ALG_W  = $clog2(ALGS),
  localparam int STEP_W = $clog2(STEPS),
  localparam int PA_W   = ALG_W + STEP_W,
  localparam int DEPTH  = ALGS * STEPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PA_W-1:0]   waddr,
  input  logic [UW-1:0]     wdata,
  input  logic [ALG_W-1:0]  rd_alg,
  input  logic              load,
  input  logic [STEP_W-1:0] rd_step,
  output logic [UW-1:0]     word
);
  logic [UW-1:0] mem [DEPTH];
  logic [UW-1:0] row_q [STEPS];
  logic [UW-1:0] row_d [STEPS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    for (int s = 0; s < STEPS; s++) begin
      row_d[s] = row_q[s];
      if (load) begin
        row_d[s] = mem[{rd_alg, STEP_W'(s)}];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STEPS; s++) begin
        row_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < STEPS; s++) begin
        row_q[s] <= row_d[s];
      end
    end
  end

  assign word = load ? mem[{rd_alg, {STEP_W{1'b0}}}] : row_q[rd_step];
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer #(
  parameter int SLOTS  = fseq_pkg::DEF_SLOTS,
  parameter int STEPS  = fseq_pkg::DEF_STEPS,
  parameter int ALGS   = fseq_pkg::DEF_ALGS,
  parameter int UW     = fseq_pkg::DEF_UW,
  parameter int NBANKS = fseq_pkg::DEF_NBANKS,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int STEP_W = $clog2(STEPS),
  localparam int ALG_W  = $clog2(ALGS),
  localparam int PA_W   = ALG_W + STEP_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tbl_we,
  input  logic [SLOT_W-1:0]        tbl_slot,
  input  logic [ALG_W-1:0]         tbl_alg,
  input  logic                     tbl_link,
  input  logic                     prog_we,
  input  logic [PA_W-1:0]          prog_addr,
  input  logic [UW-1:0]            prog_data,
  output logic [UW-1:0]            uinstr_o,
  output logic [SLOT_W-1:0]        slot_o,
  output logic [STEP_W-1:0]        step_o,
  output logic                     frame_start_o,
  output logic                     slot_start_o,
  output logic                     link_continue_o,
  output logic [NBANKS*SLOT_W-1:0] bank_base_o
);
  logic              core_rst_n;
  logic [SLOT_W-1:0] slot_c;
  logic [STEP_W-1:0] step_c;
  logic              first_step;
  logic              frame_head;
  logic [ALG_W-1:0]  tbl_rd_alg;
  logic              tbl_rd_link;
  logic [UW-1:0]     word_c;

  fseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (core_rst_n)
  );

  fseq_counter #(.SLOTS(SLOTS), .STEPS(STEPS)) u_cnt (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .slot_c     (slot_c),
    .step_c     (step_c),
    .first_step (first_step),
    .frame_head (frame_head)
  );

  fseq_slot_table #(.SLOTS(SLOTS), .ALGS(ALGS)) u_tbl (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .we      (tbl_we),
    .wslot   (tbl_slot),
    .walg    (tbl_alg),
    .wlink   (tbl_link),
    .rd_slot (slot_c),
    .rd_alg  (tbl_rd_alg),
    .rd_link (tbl_rd_link)
  );

  fseq_prog_store #(.ALGS(ALGS), .STEPS(STEPS), .UW(UW)) u_prog (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .we      (prog_we),
    .waddr   (prog_addr),
    .wdata   (prog_data),
    .rd_alg  (tbl_rd_alg),
    .load    (first_step),
    .rd_step (step_c),
    .word    (word_c)
  );

  // Chaining bit held for the whole slot
  logic link_hold_q, link_hold_d, link_cur;

  always_comb begin
    link_cur    = first_step ? tbl_rd_link : link_hold_q;
    link_hold_d = link_cur;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      link_hold_q <= 1'b0;
    end else begin
      link_hold_q <= link_hold_d;
    end
  end

  // Aligned output stage
  logic [UW-1:0]     instr_q, instr_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              fstart_q, fstart_d;
  logic              sstart_q, sstart_d;
  logic              link_q, link_d;

  always_comb begin
    instr_d  = word_c;
    slot_d   = slot_c;
    step_d   = step_c;
    fstart_d = frame_head;
    sstart_d = first_step;
    link_d   = link_cur;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      instr_q  <= '0;
      slot_q   <= '0;
      step_q   <= '0;
      fstart_q <= 1'b0;
      sstart_q <= 1'b0;
      link_q   <= 1'b0;
    end else begin
      instr_q  <= instr_d;
      slot_q   <= slot_d;
      step_q   <= step_d;
      fstart_q <= fstart_d;
      sstart_q <= sstart_d;
      link_q   <= link_d;
    end
  end

  // One registered address copy per parameter bank
  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [SLOT_W-1:0] base_q;

    always_ff @(posedge clk or negedge core_rst_n) begin
      if (!core_rst_n) begin
        base_q <= '0;
      end else begin
        base_q <= slot_c;
      end
    end

    assign bank_base_o[b*SLOT_W +: SLOT_W] = base_q;
  end

  assign uinstr_o        = instr_q;
  assign slot_o          = slot_q;
  assign step_o          = step_q;
  assign frame_start_o   = fstart_q;
  assign slot_start_o    = sstart_q;
  assign link_continue_o = link_q;
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
  parameter int SLOTS  = 64,
  parameter int STEPS  = 16,
  parameter int NBANKS = 5,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int STEP_W = $clog2(STEPS)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [SLOT_W-1:0]        slot_o,
  input logic [STEP_W-1:0]        step_o,
  input logic                     frame_start_o,
  input logic                     slot_start_o,
  input logic                     link_continue_o,
  input logic [NBANKS*SLOT_W-1:0] bank_base_o
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r1_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    armed && (step_o != STEP_LAST) |=> (step_o == $past(step_o) + 1'b1) && $stable(slot_o));

  a_r1_slot_advance: assert property (@(posedge clk) disable iff (!rst_n)
    armed && (step_o == STEP_LAST) |=> (step_o == '0) &&
      (slot_o == (($past(slot_o) == SLOT_LAST) ? '0 : $past(slot_o) + 1'b1)));

  a_r5_link_steady: assert property (@(posedge clk) disable iff (!rst_n)
    armed && (step_o != STEP_LAST) |=> $stable(link_continue_o));

  a_r6_frame_pos: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> (slot_o == '0) && (step_o == '0) && slot_start_o);

  a_r6_slot_pos: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (slot_start_o == (step_o == '0)));

  a_r7_bank_copy: assert property (@(posedge clk) disable iff (!rst_n)
    bank_base_o == {NBANKS{slot_o}});
endmodule

bind frame_sequencer fseq_checker #(.SLOTS(SLOTS), .STEPS(STEPS), .NBANKS(NBANKS)) u_chk (
  .clk             (clk),
  .rst_n           (core_rst_n),
  .slot_o          (slot_o),
  .step_o          (step_o),
  .frame_start_o   (frame_start_o),
  .slot_start_o    (slot_start_o),
  .link_continue_o (link_continue_o),
  .bank_base_o     (bank_base_o)
);

// File: tb/sim_frame_sequencer.sv
module sim_frame_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_we;
  logic [5:0]  tbl_slot;
  logic [4:0]  tbl_alg;
  logic        tbl_link;
  logic        prog_we;
  logic [8:0]  prog_addr;
  logic [31:0] prog_data;
  logic [31:0] uinstr_o;
  logic [5:0]  slot_o;
  logic [3:0]  step_o;
  logic        frame_start_o, slot_start_o, link_continue_o;
  logic [29:0] bank_base_o;

  always #5 clk = ~clk;

  frame_sequencer u0 (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_mem [512];
  logic [4:0]  m_alg [64];
  logic        m_link [64];
  logic [31:0] cur_row [16];
  logic        cur_link;
  logic [5:0]  es;
  logic [3:0]  et;
  logic [3:0]  last_t;
  string       itag;

  function automatic logic [31:0] wfun(int a, int s, int salt);
    return 32'(((a * 16 + s + 1) * 32'h9E3779B9) ^ (salt * 32'h01010101));
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at slot %0d step %0d: act=%h exp=%h", tag, what, es, et, act, exp);
    end
  endtask

  // One cycle of comparison against the model of position es/et
  task automatic tick();
    @(negedge clk);
    if (et == 0) begin
      for (int s = 0; s < 16; s++) cur_row[s] = m_mem[m_alg[es] * 16 + s];
      cur_link = m_link[es];
    end
    chk(slot_o == es && step_o == et, "R1", "position", {slot_o, step_o}, {es, et});
    chk(uinstr_o == cur_row[et], itag, "word", uinstr_o, cur_row[et]);
    chk(link_continue_o == cur_link, "R5", "link", link_continue_o, cur_link);
    chk(frame_start_o == (es == 0 && et == 0), "R6", "frame strobe", frame_start_o, (es == 0 && et == 0));
    chk(slot_start_o == (et == 0), "R6", "slot strobe", slot_start_o, (et == 0));
    chk(bank_base_o == {5{es}}, "R7", "bank bases", bank_base_o, {5{es}});
    last_t = et;
    et = et + 1;
    if (et == 0) es = es + 1;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr_tbl(int s, int a, bit l);
    while (last_t == 15) tick();
    tbl_we = 1; tbl_slot = 6'(s); tbl_alg = 5'(a); tbl_link = l;
    m_alg[s] = 5'(a); m_link[s] = l;
    tick();
    tbl_we = 0;
  endtask

  task automatic wr_prog(int a, int s, logic [31:0] d);
    while (last_t == 15) tick();
    prog_we = 1; prog_addr = 9'(a * 16 + s); prog_data = d;
    m_mem[a * 16 + s] = d;
    tick();
    prog_we = 0;
  endtask

  task automatic wait_pos(int s, int t);
    while (!(es == 6'(s) && et == 4'(t))) tick();
    tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog expired: act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit found;
    rst_n = 0; tbl_we = 0; tbl_slot = 0; tbl_alg = 0; tbl_link = 0;
    prog_we = 0; prog_addr = 0; prog_data = 0;
    es = 0; et = 0; last_t = 0; itag = "R8"; cur_link = 0;
    for (int s = 0; s < 64; s++) begin m_alg[s] = 0; m_link[s] = 0; end

    // R8: load the program store while reset is held, check outputs stay 0
    for (int a = 0; a < 32; a++) begin
      for (int s = 0; s < 16; s++) begin
        @(negedge clk);
        prog_we = 1; prog_addr = 9'(a * 16 + s); prog_data = wfun(a, s, 0);
        m_mem[a * 16 + s] = wfun(a, s, 0);
        if (s == 0) begin
          chk(uinstr_o == 0 && slot_o == 0 && step_o == 0 && !frame_start_o && !slot_start_o
              && !link_continue_o && bank_base_o == 0, "R8", "reset outputs",
              {uinstr_o, slot_o, step_o, bank_base_o[23:0]}, 64'd0);
        end
      end
    end
    @(negedge clk);
    prog_we = 0;
    // R8: table write during reset is ignored (model keeps index 0, link 0)
    tbl_we = 1; tbl_slot = 6'd5; tbl_alg = 5'd9; tbl_link = 1;
    @(negedge clk);
    tbl_we = 0;
    rst_n = 1;

    // R8: first frame strobe within a few cycles of release
    found = 0;
    for (int i = 0; i < 6 && !found; i++) begin
      @(negedge clk);
      if (frame_start_o) found = 1;
    end
    chk(found, "R8", "start after reset", found, 1);
    // the strobe cycle is slot 0 step 0; check it, then continue
    es = 0; et = 0;
    for (int s = 0; s < 16; s++) cur_row[s] = m_mem[s];
    cur_link = 0;
    chk(uinstr_o == cur_row[0] && slot_o == 0 && step_o == 0, "R8", "first word",
        uinstr_o, cur_row[0]);
    last_t = 0; et = 1;

    // R8: remainder of the first frame runs algorithm 0 everywhere
    run(1023);

    // R3 boundary: load the table while running
    itag = "R3";
    for (int s = 0; s < 64; s++) wr_tbl(s, (s * 7 + 3) % 32, (s % 5) == 2);
    run(1024);

    // R2: full sweep with distinct words per {algorithm, step}
    itag = "R2";
    run(2048);

    // R3: rewrite the running slot and the next one mid-slot
    itag = "R3";
    wait_pos(10, 3);
    wr_tbl(10, 20, 1);
    wr_tbl(11, 21, 0);
    run(2048);

    // R4: rewrite a word of the running algorithm mid-slot
    itag = "R4";
    wait_pos(20, 4);
    wr_prog(m_alg[20], 10, 32'hDEAD_BEEF);
    wr_prog(m_alg[20], 15, 32'h1234_5678);
    run(2048);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule